// File: doc/BRIEF.md
# Complementary PWM Phase Pair with Asymmetric Dead Time

This block produces one complementary pair of pulse-width-modulated outputs from a symmetric triangle carrier. A 16-bit up/down counter climbs from zero to a programmed turning value and falls back, so one carrier period lasts twice the turning value in clock cycles. The duty value is compared against the counter to form a phase request. The positive output follows the request and the inverse output follows its complement.

A separate dead-time down-counter is reloaded each time the request changes. It holds both outputs inactive for a programmable interval before the newly selected output turns on. The rising-side and falling-side intervals are set independently, so the two commutations can have unequal dead times. Each output has its own polarity-inversion bit.

The turning value and the duty value are written into buffers. They are copied into the working copies only at the carrier's bottom point, or at any time while counting is stopped. Two sticky flags record carrier bottoms and dead-time expiries. Software writes registers through a single-cycle parallel write port.

Top module: `cpwm_pair`

## Requirements
- R1: After reset both outputs are low, both flags are clear, counting is stopped, and both inversion bits are 0.
- R2: The write port decodes these addresses:
  - 0: control. Bit 0 is the run bit, bit 1 inverts the positive output, bit 2 inverts the inverse output.
  - 1: turning value P.
  - 2: duty D.
  - 3: rising dead time DR.
  - 4: falling dead time DF.
  - 5: flag clear. Bit 0 is the bottom flag, bit 1 is the dead-time flag.

  While the run bit is 0, the counter is held at zero and both outputs stay at their inactive level.
- R3: While running, the counter steps 0,1,…,P,P-1,…,1,0 and repeats. The carrier period is 2·P cycles for P ≥ 1.
- R4: The phase request is active while the counter is below D. For 1 ≤ D ≤ P, the positive output is active for 2·D−1−(DR+1) cycles per period, provided this is positive. The inverse output is active for 2·P−(2·D−1)−(DF+1) cycles per period.
- R5: When the request turns active, both outputs stay inactive for DR+1 cycles before the positive output turns on.
- R6: When the request turns inactive, both outputs stay inactive for DF+1 cycles before the inverse output turns on.
- R7: With D = 0 the positive output is never active and the inverse output is always active. With D > P the positive output is always active and the inverse output is never active.
- R8: The two outputs are never active in the same cycle.
- R9: An inversion bit of 1 makes the corresponding output active-low. Its inactive level, including while stopped, is then high.
- R10: While running, P and D writes take effect only at the carrier bottom, so a running period completes with the old values.
- R11: The bottom flag sets each time the counter returns to zero. The dead-time flag sets each time a dead-time interval expires. Both flags hold until a write to address 5 with the matching bit set to 1; a 0 bit leaves its flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 16 | Register write data |
| pos_o | output | 1 | Positive-phase output |
| neg_o | output | 1 | Inverse-phase output |
| bot_flag_o | output | 1 | Sticky carrier-bottom flag |
| dly_flag_o | output | 1 | Sticky dead-time-expiry flag |

## Verification
A wrong counter direction or turning point shows up within one carrier period as a changed gap between successive positive pulses. A corrupted dead-time counter changes the measured inactive gaps at the very next commutation. A working copy of the duty value that updates early removes or shortens the pulse that straddles the next bottom, so it appears within one period of the write. A flag that fails to stick or to clear shows on the flag pins in the cycle after the relevant write.

// File: rtl/cpwm_pkg.sv
// Package: shared register addresses and field positions for the PWM pair.
// Assumes a 3-bit address space; unused addresses are ignored.
package cpwm_pkg;
    typedef enum logic [2:0] {
        ADDR_CTRL = 3'd0,
        ADDR_PER  = 3'd1,
        ADDR_DUTY = 3'd2,
        ADDR_DT_R = 3'd3,
        ADDR_DT_F = 3'd4,
        ADDR_STAT = 3'd5
    } reg_addr_e;

    localparam int CTRL_RUN   = 0;
    localparam int CTRL_INV_P = 1;
    localparam int CTRL_INV_N = 2;
    localparam int STAT_BOT   = 0;
    localparam int STAT_DLY   = 1;
endpackage

// File: rtl/cpwm_regs.sv
// Register file: control bits, buffered turning value and duty, dead times,
// and the two sticky flags. Assumes single-cycle writes; a flag set event
// wins over a clear in the same cycle.
module cpwm_regs
    import cpwm_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [2:0]    wr_addr,
    input  logic [CW-1:0] wr_data,
    input  logic          evt_bot,
    input  logic          evt_dly,
    output logic          run,
    output logic          inv_pos,
    output logic          inv_neg,
    output logic [CW-1:0] per_buf,
    output logic [CW-1:0] duty_buf,
    output logic [CW-1:0] dt_rise,
    output logic [CW-1:0] dt_fall,
    output logic          flag_bot,
    output logic          flag_dly
);
    logic clr_bot, clr_dly;

    // Decode write-one-to-clear requests for the flags.
    always_comb begin
        clr_bot = wr_en && (wr_addr == ADDR_STAT) && wr_data[STAT_BOT];
        clr_dly = wr_en && (wr_addr == ADDR_STAT) && wr_data[STAT_DLY];
    end

    // Store configuration writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run      <= 1'b0;
            inv_pos  <= 1'b0;
            inv_neg  <= 1'b0;
            per_buf  <= '0;
            duty_buf <= '0;
            dt_rise  <= '0;
            dt_fall  <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                ADDR_CTRL: begin
                    run     <= wr_data[CTRL_RUN];
                    inv_pos <= wr_data[CTRL_INV_P];
                    inv_neg <= wr_data[CTRL_INV_N];
                end
                ADDR_PER:  per_buf  <= wr_data;
                ADDR_DUTY: duty_buf <= wr_data;
                ADDR_DT_R: dt_rise  <= wr_data;
                ADDR_DT_F: dt_fall  <= wr_data;
                default: ;
            endcase
        end
    end

    // Sticky flags: set by events, cleared by write-one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_bot <= 1'b0;
            flag_dly <= 1'b0;
        end else begin
            if (evt_bot)      flag_bot <= 1'b1;
            else if (clr_bot) flag_bot <= 1'b0;
            if (evt_dly)      flag_dly <= 1'b1;
            else if (clr_dly) flag_dly <= 1'b0;
        end
    end
endmodule

// File: rtl/cpwm_carrier.sv
// Triangle carrier: counts 0..P..0 while running and holds working copies of
// the turning value and duty, refreshed at the bottom or while stopped.
// Assumes P >= 1 (P = 0 behaves as P = 1).
module cpwm_carrier #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [CW-1:0] per_buf,
    input  logic [CW-1:0] duty_buf,
    output logic [CW-1:0] cnt,
    output logic [CW-1:0] per_act,
    output logic [CW-1:0] duty_act,
    output logic          bot_evt,
    output logic          raw_req
);
    logic          dir_up;
    logic [CW:0]   nxt_up;

    // Bottom event, next up value and phase request.
    always_comb begin
        bot_evt = run && !dir_up && (cnt == CW'(1));
        nxt_up  = {1'b0, cnt} + {{CW{1'b0}}, 1'b1};
        raw_req = duty_act > cnt;
    end

    // Step the counter and reload working copies at the bottom.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt      <= '0;
            dir_up   <= 1'b1;
            per_act  <= '0;
            duty_act <= '0;
        end else if (!run) begin
            cnt      <= '0;
            dir_up   <= 1'b1;
            per_act  <= per_buf;
            duty_act <= duty_buf;
        end else begin
            if (dir_up) begin
                cnt <= nxt_up[CW-1:0];
                if (nxt_up >= {1'b0, per_act}) dir_up <= 1'b0;
            end else begin
                cnt <= cnt - CW'(1);
                if (cnt == CW'(1)) dir_up <= 1'b1;
            end
            if (bot_evt) begin
                per_act  <= per_buf;
                duty_act <= duty_buf;
            end
        end
    end
endmodule

// File: rtl/cpwm_deadtime.sv
// Dead-time unit: a down-counter reloaded on every change of the phase
// request keeps both outputs inactive for (delay + 1) cycles, then enables
// the selected output. Outputs here are active-high.
module cpwm_deadtime #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          raw_req,
    input  logic [CW-1:0] dt_rise,
    input  logic [CW-1:0] dt_fall,
    output logic          pos_act,
    output logic          neg_act,
    output logic          dly_evt
);
    logic          raw_q, gap, chg;
    logic [CW-1:0] dly;

    // Detect request changes and dead-time expiry.
    always_comb begin
        chg     = raw_req != raw_q;
        dly_evt = run && gap && !chg && (dly == '0);
    end

    // Sequence the gap and the complementary outputs.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            raw_q   <= 1'b0;
            gap     <= 1'b0;
            dly     <= '0;
            pos_act <= 1'b0;
            neg_act <= 1'b0;
        end else if (chg) begin
            raw_q   <= raw_req;
            gap     <= 1'b1;
            dly     <= raw_req ? dt_rise : dt_fall;
            pos_act <= 1'b0;
            neg_act <= 1'b0;
        end else if (gap && dly != '0) begin
            dly <= dly - CW'(1);
        end else begin
            gap     <= 1'b0;
            pos_act <= raw_q;
            neg_act <= !raw_q;
        end
    end
endmodule

// File: rtl/cpwm_pair.sv
// Top: complementary PWM phase pair with independent rising and falling
// dead times, per-output polarity and sticky event flags.
module cpwm_pair #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [2:0]    wr_addr,
    input  logic [CW-1:0] wr_data,
    output logic          pos_o,
    output logic          neg_o,
    output logic          bot_flag_o,
    output logic          dly_flag_o
);
    logic          run, inv_pos, inv_neg, bot_evt, dly_evt, raw_req;
    logic          pos_act, neg_act;
    logic [CW-1:0] per_buf, duty_buf, dt_rise, dt_fall;
    logic [CW-1:0] cnt, per_act, duty_act;

    cpwm_regs #(.CW(CW)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .evt_bot(bot_evt), .evt_dly(dly_evt),
        .run(run), .inv_pos(inv_pos), .inv_neg(inv_neg),
        .per_buf(per_buf), .duty_buf(duty_buf),
        .dt_rise(dt_rise), .dt_fall(dt_fall),
        .flag_bot(bot_flag_o), .flag_dly(dly_flag_o)
    );

    cpwm_carrier #(.CW(CW)) u_carrier (
        .clk(clk), .rst_n(rst_n), .run(run),
        .per_buf(per_buf), .duty_buf(duty_buf),
        .cnt(cnt), .per_act(per_act), .duty_act(duty_act),
        .bot_evt(bot_evt), .raw_req(raw_req)
    );

    cpwm_deadtime #(.CW(CW)) u_dead (
        .clk(clk), .rst_n(rst_n), .run(run), .raw_req(raw_req),
        .dt_rise(dt_rise), .dt_fall(dt_fall),
        .pos_act(pos_act), .neg_act(neg_act), .dly_evt(dly_evt)
    );

    // Apply per-output polarity.
    always_comb begin
        pos_o = pos_act ^ inv_pos;
        neg_o = neg_act ^ inv_neg;
    end
endmodule

// File: rtl/cpwm_pair_chk.sv
// Checker bound to cpwm_pair: temporal properties over the outputs,
// carrier and register state.
module cpwm_pair_chk #(
    parameter int CW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          run,
    input logic          pos_act,
    input logic          neg_act,
    input logic [CW-1:0] cnt,
    input logic [CW-1:0] per_act,
    input logic [CW-1:0] duty_act,
    input logic          bot_evt,
    input logic          bot_flag_o,
    input logic          wr_en,
    input logic [2:0]    wr_addr,
    input logic [CW-1:0] wr_data
);
    assert_stopped_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (!pos_act && !neg_act));

    assert_count_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt <= ((per_act == '0) ? CW'(1) : per_act)));

    assert_rise_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pos_act) |-> $past(!neg_act));

    assert_fall_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(neg_act) |-> $past(!pos_act));

    assert_outputs_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(pos_act && neg_act));

    assert_duty_shadow_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(duty_act) |-> $past(bot_evt || !run));

    assert_bot_flag_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (bot_flag_o && !(wr_en && wr_addr == 3'd5 && wr_data[0])) |=> bot_flag_o);
endmodule

bind cpwm_pair cpwm_pair_chk #(.CW(CW)) u_chk (
    .clk(clk), .rst_n(rst_n), .run(run), .pos_act(pos_act), .neg_act(neg_act),
    .cnt(cnt), .per_act(per_act), .duty_act(duty_act), .bot_evt(bot_evt),
    .bot_flag_o(bot_flag_o), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
);

// File: tb/test_cpwm_pair.sv
`timescale 1ns/1ps
module test_cpwm_pair;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        pos_o, neg_o, bot_flag_o, dly_flag_o;
    logic        inv_p = 1'b0, inv_n = 1'b0;
    int          n_chk = 0, n_fail = 0;
    bit          done = 1'b0;

    cpwm_pair i_cpwm_pair (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .pos_o(pos_o), .neg_o(neg_o),
        .bot_flag_o(bot_flag_o), .dly_flag_o(dly_flag_o)
    );

    always #4 clk = ~clk;

    function automatic bit pa();
        return pos_o ^ inv_p;
    endfunction
    function automatic bit na();
        return neg_o ^ inv_n;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Wait until the chosen active signal equals lvl (bounded).
    task automatic wait_for(input bit on_pos, input bit lvl);
        for (int i = 0; i < 2000; i++) begin
            if ((on_pos ? pa() : na()) == lvl) return;
            @(negedge clk);
        end
    endtask

    task automatic count_while(input bit on_pos, input bit lvl, output int n);
        n = 0;
        while (((on_pos ? pa() : na()) == lvl) && n < 2000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic configure(input int p, input int d, input int r, input int f);
        wr(3'd0, 16'(inv_p << 1 | inv_n << 2));
        wr(3'd1, 16'(p)); wr(3'd2, 16'(d)); wr(3'd3, 16'(r)); wr(3'd4, 16'(f));
        wr(3'd0, 16'(1 | inv_p << 1 | inv_n << 2));
        cycles(6 * p + 20);
    endtask

    task automatic t_reset();
        chk(pos_o == 1'b0, "R1 pos_o", pos_o, 0);
        chk(neg_o == 1'b0, "R1 neg_o", neg_o, 0);
        chk(bot_flag_o == 1'b0, "R1 bot_flag", bot_flag_o, 0);
        chk(dly_flag_o == 1'b0, "R1 dly_flag", dly_flag_o, 0);
    endtask

    task automatic t_stopped();
        int act_p = 0, act_n = 0;
        wr(3'd1, 16'd8); wr(3'd2, 16'd3); wr(3'd0, 16'd0);
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            act_p += int'(pa()); act_n += int'(na());
        end
        chk(act_p == 0, "R2 pos idle while stopped", act_p, 0);
        chk(act_n == 0, "R2 neg idle while stopped", act_n, 0);
    endtask

    // Measure one full positive/gap/inverse/gap cycle.
    task automatic t_widths(input int p, input int d, input int r, input int f);
        int pw, g1, nw, g2, both;
        configure(p, d, r, f);
        wait_for(1'b1, 1'b0);
        wait_for(1'b1, 1'b1);
        count_while(1'b1, 1'b1, pw);
        count_while(1'b0, 1'b0, g1);
        count_while(1'b0, 1'b1, nw);
        count_while(1'b1, 1'b0, g2);
        chk(pw == 2*d - 1 - (r+1), "R4 positive width", pw, 2*d - 1 - (r+1));
        chk(nw == 2*p - (2*d-1) - (f+1), "R4 inverse width", nw, 2*p - (2*d-1) - (f+1));
        chk(g1 == f + 1, "R6 falling dead gap", g1, f + 1);
        chk(g2 == r + 1, "R5 rising dead gap", g2, r + 1);
        chk(pw + g1 + nw + g2 == 2*p, "R3 carrier period", pw + g1 + nw + g2, 2*p);
        both = 0;
        for (int i = 0; i < 4*p; i++) begin
            @(negedge clk);
            if (pa() && na()) both++;
        end
        chk(both == 0, "R8 both outputs active", both, 0);
        wr(3'd0, 16'd0);
    endtask

    task automatic t_extremes();
        int ap, an;
        configure(8, 0, 1, 2);
        ap = 0; an = 0;
        for (int i = 0; i < 32; i++) begin
            @(negedge clk); ap += int'(pa()); an += int'(na());
        end
        chk(ap == 0, "R7 duty 0 positive count", ap, 0);
        chk(an == 32, "R7 duty 0 inverse count", an, 32);
        wr(3'd2, 16'd9);
        cycles(40);
        ap = 0; an = 0;
        for (int i = 0; i < 32; i++) begin
            @(negedge clk); ap += int'(pa()); an += int'(na());
        end
        chk(ap == 32, "R7 duty above P positive count", ap, 32);
        chk(an == 0, "R7 duty above P inverse count", an, 0);
        wr(3'd0, 16'd0);
    endtask

    task automatic t_invert();
        int pw;
        inv_p = 1'b1; inv_n = 1'b1;
        wr(3'd0, 16'd6);
        cycles(3);
        chk(pos_o == 1'b1, "R9 inverted idle pos level", pos_o, 1);
        chk(neg_o == 1'b1, "R9 inverted idle neg level", neg_o, 1);
        configure(8, 3, 1, 2);
        wait_for(1'b1, 1'b0);
        wait_for(1'b1, 1'b1);
        chk(pos_o == 1'b0, "R9 active-low positive pin", pos_o, 0);
        count_while(1'b1, 1'b1, pw);
        chk(pw == 3, "R9 inverted positive width", pw, 3);
        wr(3'd0, 16'd6);
        inv_p = 1'b0; inv_n = 1'b0;
        wr(3'd0, 16'd0);
    endtask

    task automatic t_buffer();
        int seen_old, seen_new;
        configure(8, 4, 0, 0);
        wr(3'd5, 16'd1);
        for (int i = 0; i < 100 && !bot_flag_o; i++) @(negedge clk);
        cycles(3);
        wr(3'd2, 16'd0);
        seen_old = 0;
        for (int i = 0; i < 16; i++) begin
            @(negedge clk); seen_old += int'(pa());
        end
        chk(seen_old > 0, "R10 old duty kept until bottom", seen_old, 2);
        cycles(16);
        seen_new = 0;
        for (int i = 0; i < 32; i++) begin
            @(negedge clk); seen_new += int'(pa());
        end
        chk(seen_new == 0, "R10 new duty after bottom", seen_new, 0);
        wr(3'd0, 16'd0);
    endtask

    task automatic t_flags();
        configure(8, 3, 1, 2);
        chk(bot_flag_o == 1'b1, "R11 bottom flag set", bot_flag_o, 1);
        chk(dly_flag_o == 1'b1, "R11 dead-time flag set", dly_flag_o, 1);
        wr(3'd0, 16'd0);
        wr(3'd5, 16'd0);
        chk(bot_flag_o && dly_flag_o, "R11 zero write keeps flags",
            int'(bot_flag_o) + int'(dly_flag_o), 2);
        wr(3'd5, 16'd1);
        chk(bot_flag_o == 1'b0, "R11 bottom flag cleared", bot_flag_o, 0);
        chk(dly_flag_o == 1'b1, "R11 dead-time flag untouched", dly_flag_o, 1);
        wr(3'd5, 16'd2);
        chk(dly_flag_o == 1'b0, "R11 dead-time flag cleared", dly_flag_o, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_stopped();
        t_widths(8, 3, 1, 2);
        t_widths(10, 5, 0, 3);
        t_extremes();
        t_invert();
        t_buffer();
        t_flags();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule